// File: doc/BRIEF.md
# SPI Command-Framed Register Store

This block is an SPI slave (clock idle low, data captured on the rising serial-clock edge, launched on the falling one) that answers the same small command set as a serial EEPROM. The SPI pins are oversampled by the system clock. Every command is framed by the active-low select. The first byte after select falls is always the opcode. Any address and data bytes follow it.

Four opcodes are understood. Arm (0x06) sets a write-enable latch. Status (0x05) streams the status byte back. Store (0x02) writes one byte into a small register array. Fetch (0x03) reads bytes back in sequence. A store does not change the array while its bytes are being clocked in. It takes effect only when select rises at a byte boundary. It then clears the latch and starts a busy window lasting a set number of system clocks. During that window only the status command is answered.

Top module: `spi_regstore`

## Requirements
- R1: After reset, MISO is low, the status byte reads 0x00 and every array entry reads 0x00.
- R2: The first byte after a falling select is the opcode. MISO is 0 during the opcode byte unless the opcode is status, and MISO is 0 at all times while select is high.
- R3: A frame with exactly one byte, 0x06, ending on a byte boundary, sets the write-enable latch (status bit 1) when select rises. A frame of 0x06 followed by further bytes or by stray bits leaves the latch unchanged.
- R4: After opcode 0x05, each following byte shifts out the status {6'b0, latch, busy} MSB first. Busy is status bit 0. The value is sampled at the end of the preceding byte, and the stream repeats for as long as select stays low.
- R5: Opcode 0x02 is followed by a 16-bit address, MSB first, and then data bytes. At the rising select, the first data byte is written to the entry given by the low log2(MEM_DEPTH) address bits (16 entries by default). Later data bytes and the higher address bits are ignored.
- R6: A store frame that starts while the write-enable latch is clear changes nothing.
- R7: A store frame whose select rises partway through a byte changes nothing, and the latch stays set.
- R8: A committed store clears the latch and holds busy high for BUSY_CYCLES system clocks after select rises.
- R9: While busy is set, every opcode except 0x05 is ignored. Arm does not set the latch, store does not write, and fetch returns 0x00.
- R10: Opcode 0x03 is followed by a 16-bit address. The addressed entry is shifted out MSB first in the byte after the address, and each further byte returns the next entry, wrapping from the last entry to entry 0.
- R11: Any other opcode is ignored for the rest of its frame, and MISO stays 0.
- R12: MOSI is captured on rising serial-clock edges, and MISO changes only after a falling serial-clock edge or a select edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csn | input | 1 | Active-low select that frames each command |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block, driven low when idle |

## Verification
The assertions rely on the SPI pins being slow relative to the system clock. Every serial-clock phase, and every gap between a select edge and a serial-clock edge, must last longer than the synchronizer depth plus one cycle. Select must change only while the serial clock is low. The stimulus meets these conditions with six-clock half periods and four-clock guards around each select edge. It waits out busy windows by elapsed cycle count, and it keeps status samples well away from the busy boundary, so the reference model and the design cannot disagree by a clock.

// File: rtl/spi_regstore_pkg.sv
package spi_regstore_pkg;

  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_STORE  = 8'h02;
  localparam logic [7:0] OP_FETCH  = 8'h03;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_OPCODE,
    PH_ARM,
    PH_STATUS,
    PH_STORE,
    PH_FETCH,
    PH_DROP
  } phase_t;

endpackage

// File: rtl/spi_regstore_sync.sv
module spi_regstore_sync #(
  parameter int                 WIDTH     = 3,
  parameter int                 STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RESET_VAL[g]}};
        prev_q  <= RESET_VAL[g];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign level[g] = chain_q[STAGES-1];
    assign rise[g]  = chain_q[STAGES-1] & ~prev_q;
    assign fall[g]  = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/spi_regstore_frame.sv
module spi_regstore_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csn_lvl,
  input  logic       csn_fall,
  input  logic       csn_rise,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_lvl,
  input  logic [7:0] tx_next,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       aligned,
  output logic       miso
);

  logic [2:0] bit_cnt_q, bit_cnt_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic       miso_q, miso_d;

  assign byte_done = !csn_lvl && !csn_fall && sck_rise && (bit_cnt_q == 3'd7);
  assign rx_byte   = {rx_q, mosi_lvl};
  assign aligned   = (bit_cnt_q == 3'd0);
  assign miso      = miso_q;

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    miso_d    = miso_q;
    if (csn_fall || csn_rise) begin
      bit_cnt_d = 3'd0;
      tx_d      = 8'h00;
      miso_d    = 1'b0;
    end else if (!csn_lvl) begin
      if (sck_rise) begin
        rx_d      = {rx_q[5:0], mosi_lvl};
        bit_cnt_d = bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) tx_d = tx_next;
      end else if (sck_fall) begin
        miso_d = tx_q[7];
        tx_d   = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= 3'd0;
      rx_q      <= 7'd0;
      tx_q      <= 8'h00;
      miso_q    <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      miso_q    <= miso_d;
    end
  end

  // R2: the output returns low once select is seen high
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    csn_rise |=> !miso_q);

  // R2: a new frame starts with a cleared bit count and a low output
  a_r2_frame_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
    csn_fall |=> (bit_cnt_q == 3'd0) && !miso_q);

  // R12: the output moves only after a falling clock or a select edge
  a_r12_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> ($past(sck_fall) || $past(csn_rise) || $past(csn_fall)));

endmodule

// File: rtl/spi_regstore_array.sv
module spi_regstore_array #(
  parameter int MEM_DEPTH = 16,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] entry_q [MEM_DEPTH];

  for (genvar e = 0; e < MEM_DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[e] <= 8'h00;
      else if (hit) entry_q[e] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/spi_regstore_ctrl.sv
module spi_regstore_ctrl
  import spi_regstore_pkg::*;
#(
  parameter int MEM_DEPTH   = 16,
  parameter int BUSY_CYCLES = 300,
  localparam int IDX_W      = $clog2(MEM_DEPTH),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             aligned,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  output logic [7:0]       tx_next,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_widx,
  output logic [7:0]       mem_wdata,
  output logic [IDX_W-1:0] mem_ridx,
  input  logic [7:0]       mem_rdata
);

  phase_t           ph_q, ph_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [7:0]       ahi_q, ahi_d;
  logic [7:0]       alo_q, alo_d;
  logic [7:0]       wdata_q, wdata_d;
  logic             armed_q, armed_d;
  logic             wel_q, wel_d;
  logic [CNT_W-1:0] busy_q, busy_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             wip, commit, arm_set;
  logic [7:0]       status_byte;

  assign wip         = (busy_q != '0);
  assign status_byte = {6'b0, wel_q, wip};
  assign commit      = frame_end && (ph_q == PH_STORE) && armed_q && aligned;
  assign arm_set     = frame_end && (ph_q == PH_ARM) && aligned && (cnt_q == 3'd1);

  assign mem_we    = commit;
  assign mem_widx  = IDX_W'({ahi_q, alo_q});
  assign mem_wdata = wdata_q;
  assign mem_ridx  = (cnt_q == 3'd2) ? IDX_W'({ahi_q, rx_byte}) : ptr_q;

  always_comb begin
    tx_next = 8'h00;
    case (ph_q)
      PH_OPCODE: if (rx_byte == OP_STATUS) tx_next = status_byte;
      PH_STATUS: tx_next = status_byte;
      PH_FETCH:  if (cnt_q >= 3'd2) tx_next = mem_rdata;
      default:   tx_next = 8'h00;
    endcase
  end

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    ahi_d   = ahi_q;
    alo_d   = alo_q;
    wdata_d = wdata_q;
    armed_d = armed_q;
    ptr_d   = ptr_q;
    wel_d   = wel_q;
    busy_d  = busy_q;

    if (commit)       wel_d = 1'b0;
    else if (arm_set) wel_d = 1'b1;

    if (commit)   busy_d = CNT_W'(BUSY_CYCLES);
    else if (wip) busy_d = busy_q - CNT_W'(1);

    if (frame_start) begin
      ph_d    = PH_OPCODE;
      cnt_d   = 3'd0;
      armed_d = 1'b0;
    end else if (frame_end) begin
      ph_d = PH_OFF;
    end else if (byte_done) begin
      if (cnt_q != 3'd4) cnt_d = cnt_q + 3'd1;
      case (ph_q)
        PH_OPCODE: begin
          if (wip && (rx_byte != OP_STATUS)) ph_d = PH_DROP;
          else begin
            case (rx_byte)
              OP_ARM:    ph_d = PH_ARM;
              OP_STATUS: ph_d = PH_STATUS;
              OP_STORE:  ph_d = wel_q ? PH_STORE : PH_DROP;
              OP_FETCH:  ph_d = PH_FETCH;
              default:   ph_d = PH_DROP;
            endcase
          end
        end
        PH_ARM: ph_d = PH_DROP;
        PH_STORE: begin
          case (cnt_q)
            3'd1: ahi_d = rx_byte;
            3'd2: alo_d = rx_byte;
            3'd3: begin
              wdata_d = rx_byte;
              armed_d = 1'b1;
            end
            default: ;
          endcase
        end
        PH_FETCH: begin
          if (cnt_q == 3'd1)      ahi_d = rx_byte;
          else if (cnt_q == 3'd2) ptr_d = mem_ridx + IDX_W'(1);
          else if (cnt_q >= 3'd3) ptr_d = ptr_q + IDX_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_OFF;
      cnt_q   <= 3'd0;
      ahi_q   <= 8'h00;
      alo_q   <= 8'h00;
      wdata_q <= 8'h00;
      armed_q <= 1'b0;
      wel_q   <= 1'b0;
      busy_q  <= '0;
      ptr_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      ahi_q   <= ahi_d;
      alo_q   <= alo_d;
      wdata_q <= wdata_d;
      armed_q <= armed_d;
      wel_q   <= wel_d;
      busy_q  <= busy_d;
      ptr_q   <= ptr_d;
    end
  end

  // R8: a commit drops the latch and opens the busy window
  a_r8_commit_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!wel_q && wip));

  // R5: busy can only begin right after select rises
  a_r5_busy_from_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(frame_end));

  // R9: the latch cannot be set while busy
  a_r9_no_arm_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> !$rose(wel_q));

  // R6: a store commits only with the latch set
  a_r6_store_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> wel_q);

endmodule

// File: rtl/spi_regstore.sv
module spi_regstore #(
  parameter int MEM_DEPTH   = 16,
  parameter int BUSY_CYCLES = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  localparam int IDX_W = $clog2(MEM_DEPTH);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic [2:0] pin_lvl, pin_rise, pin_fall;

  spi_regstore_sync #(
    .WIDTH     (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({csn, sck, mosi}),
    .level    (pin_lvl),
    .rise     (pin_rise),
    .fall     (pin_fall)
  );

  logic             byte_done, aligned;
  logic [7:0]       rx_byte, tx_next;
  logic             mem_we;
  logic [IDX_W-1:0] mem_widx, mem_ridx;
  logic [7:0]       mem_wdata, mem_rdata;

  spi_regstore_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .csn_lvl   (pin_lvl[2]),
    .csn_fall  (pin_fall[2]),
    .csn_rise  (pin_rise[2]),
    .sck_rise  (pin_rise[1]),
    .sck_fall  (pin_fall[1]),
    .mosi_lvl  (pin_lvl[0]),
    .tx_next   (tx_next),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .aligned   (aligned),
    .miso      (miso)
  );

  spi_regstore_ctrl #(
    .MEM_DEPTH   (MEM_DEPTH),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .frame_start (pin_fall[2]),
    .frame_end   (pin_rise[2]),
    .aligned     (aligned),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .tx_next     (tx_next),
    .mem_we      (mem_we),
    .mem_widx    (mem_widx),
    .mem_wdata   (mem_wdata),
    .mem_ridx    (mem_ridx),
    .mem_rdata   (mem_rdata)
  );

  spi_regstore_array #(
    .MEM_DEPTH (MEM_DEPTH)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (mem_we),
    .wr_idx  (mem_widx),
    .wr_data (mem_wdata),
    .rd_idx  (mem_ridx),
    .rd_data (mem_rdata)
  );

endmodule

// File: tb/spi_regstore_bench.sv
`timescale 1ns/1ps
module spi_regstore_bench;

  localparam int DEPTH = 16;
  localparam int BUSY  = 300;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst_n, csn, sck, mosi;
  logic miso;

  always #5 clk = ~clk;

  spi_regstore #(.MEM_DEPTH(DEPTH), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_spi_regstore (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int last_rise = 0;
  int end_cyc = 0;
  int commit_cyc = 0;
  bit commit_seen = 0;
  bit ref_wel = 0;
  int ref_mem [DEPTH];
  int csn_high_run = 0;
  bit live = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    csn_high_run <= csn ? csn_high_run + 1 : 0;
  end

  // per-clock comparison: the output must idle low with select high (R2)
  always @(negedge clk) begin
    if (live && !done && csn && csn_high_run > 4) begin
      vectors++;
      if (miso !== 1'b0) begin
        miscompares++;
        $display("FAIL R2 idle miso: actual %b expected 0", miso);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic bit busy_at(input int c);
    return commit_seen && ((c - commit_cyc) <= BUSY);
  endfunction

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      tick(H);
      r[i] = miso;
      sck = 1'b1;
      last_rise = cyc;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic stray_bits(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      tick(H);
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    csn = 1'b0;
    tick(4);
  endtask

  task automatic cs_off();
    tick(4);
    csn = 1'b1;
    end_cyc = cyc;
    tick(8);
  endtask

  task automatic op_arm(input int extra_bytes, input int extra_bits, input string req);
    logic [7:0] r;
    bit busy;
    cs_on();
    xfer(8'h06, r);
    busy = busy_at(last_rise);
    chk({req, " opcode byte miso"}, r, 0);
    for (int k = 0; k < extra_bytes; k++) xfer(8'h00, r);
    stray_bits(extra_bits);
    cs_off();
    if (!busy && extra_bytes == 0 && extra_bits == 0) ref_wel = 1'b1;
  endtask

  task automatic op_store(input logic [15:0] addr, input logic [7:0] data,
                          input int extra_bytes, input int extra_bits);
    logic [7:0] r;
    bit ok;
    cs_on();
    xfer(8'h02, r);
    ok = ref_wel && !busy_at(last_rise);
    xfer(addr[15:8], r);
    xfer(addr[7:0], r);
    xfer(data, r);
    for (int k = 0; k < extra_bytes; k++) xfer(8'hFF, r);
    stray_bits(extra_bits);
    cs_off();
    if (ok && extra_bits == 0) begin
      ref_mem[addr[3:0]] = data;
      ref_wel = 1'b0;
      commit_cyc = end_cyc;
      commit_seen = 1'b1;
    end
  endtask

  task automatic op_fetch(input logic [15:0] addr, input int n, input string req);
    logic [7:0] r;
    bit ok;
    cs_on();
    xfer(8'h03, r);
    ok = !busy_at(last_rise);
    xfer(addr[15:8], r);
    xfer(addr[7:0], r);
    for (int k = 0; k < n; k++) begin
      xfer(8'hA5, r);
      chk(req, r, ok ? ref_mem[(addr[3:0] + k) % DEPTH] : 0);
    end
    cs_off();
  endtask

  task automatic op_status(input int n, input string req);
    logic [7:0] r;
    int prev;
    cs_on();
    xfer(8'h05, r);
    for (int k = 0; k < n; k++) begin
      prev = last_rise;
      xfer(8'h00, r);
      chk(req, r, {30'd0, ref_wel, busy_at(prev)});
    end
    cs_off();
  endtask

  task automatic op_raw(input logic [7:0] op, input int n, input string req);
    logic [7:0] r;
    cs_on();
    xfer(op, r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h5A, r);
      chk(req, r, 0);
    end
    cs_off();
  endtask

  task automatic wait_idle();
    tick(BUSY + 20);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
    rst_n = 1'b0; csn = 1'b1; sck = 1'b0; mosi = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    live = 1'b1;

    // R1: reset state
    chk("R1 miso after reset", miso, 0);
    op_status(2, "R1 R4 reset status");
    op_fetch(16'h0005, 2, "R1 R10 reset contents");

    // R6: store without the latch
    op_store(16'h0003, 8'hA5, 0, 0);
    op_fetch(16'h0003, 1, "R6 store without latch");

    // R3 and R4: arm then read status twice
    op_arm(0, 0, "R2");
    op_status(2, "R3 R4 latch set");

    // R5: commit, extra data byte ignored
    op_store(16'h1203, 8'h3C, 1, 0);
    // R9: arm and fetch during busy are ignored
    op_arm(0, 0, "R9");
    op_fetch(16'h0003, 1, "R9 fetch while busy");
    wait_idle();
    op_status(1, "R8 R9 latch cleared and idle");
    op_fetch(16'h0003, 2, "R5 R10 stored value and neighbour");

    // R8: busy window seen through repeated status
    op_arm(0, 0, "R2");
    op_store(16'h0008, 8'h5A, 0, 0);
    tick(50);
    op_status(4, "R8 R4 busy window");
    wait_idle();

    // R7: partial byte ends the store
    op_arm(0, 0, "R2");
    op_store(16'h0007, 8'h99, 0, 3);
    op_status(1, "R7 latch kept");
    op_fetch(16'h0007, 1, "R7 entry unchanged");

    // R3: arm with extra byte or stray bits after a commit cleared the latch
    op_store(16'h0000, 8'hC3, 0, 0);
    wait_idle();
    op_arm(1, 0, "R3");
    op_status(1, "R3 arm with extra byte");
    op_arm(0, 4, "R3");
    op_status(1, "R3 arm with stray bits");

    // R11: unknown opcode
    op_raw(8'h9F, 3, "R11 unknown opcode");
    op_status(1, "R11 no side effect");

    // R10 and R5: wrap and high address bits ignored
    op_arm(0, 0, "R2");
    op_store(16'hFF0F, 8'h77, 0, 0);
    wait_idle();
    op_fetch(16'h000F, 3, "R10 wrap to entry 0");
    op_fetch(16'hAB08, 1, "R5 R12 high address bits ignored");

    done = 1'b1;
    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule